// File: doc/BRIEF.md
# External Bus Hand-off Arbiter

This block decides when the processor core gives its external address bus, data bus and memory strobes to an outside bus master. The outside master pulls an active-low request pin. The block samples that pin through a synchronizer. When the core has no external memory access under way, the block floats the core's bus drivers, asserts an active-low grant pin and holds the core halted. If the core is in the middle of an external access, the grant is deferred until the access ends. When the master lets go of the request, the grant drops first. One cycle later the drivers are enabled again and the core runs on.

Every pin is a plain level control. No data passes through the block, so no valid/ready pair exists and back-pressure does not apply. The memory controller that uses the enables lies outside this block. So does the core that obeys the halt.

Top module: `bus_handoff_arbiter`

## Requirements
- R1: While reset is held and right after it, `ext_grant_n` is 1, `addr_oe`, `data_oe` and every bit of `strobe_oe` are 1, and `core_halt` is 0.
- R2: With `core_xfer_busy` low, a request driven low is answered by `ext_grant_n` going low on the (SYNC_STAGES+1)-th rising edge after the change, which is the third edge at the default of two stages.
- R3: While the grant is held, and in the release cycle that follows it, `addr_oe`, `data_oe` and all `strobe_oe` bits are 0. The strobe bit order is 0 program select, 1 data select, 2 byte select, 3 composite select, 4 I/O select, 5 read, 6 write.
- R4: `ext_grant_n` is low only while the granted state is held, and it is never low while any driver enable is 1.
- R5: `core_halt` is 1 from the edge that asserts the grant through the release cycle, and 0 at all other times.
- R6: If `core_xfer_busy` is high when the synchronized request is seen, no grant is given. The grant follows on the first rising edge at which `core_xfer_busy` is sampled low while the request is still present.
- R7: After the synchronized request is seen removed, `ext_grant_n` returns to 1 on the next edge. The enables return to 1 and `core_halt` to 0 on the edge after that.
- R8: A request that is withdrawn while the block waits for a core access to end returns the block to idle. No grant is given, no enable drops and no halt occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Processor clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ext_req_n | input | 1 | Asynchronous active-low bus request from the outside master |
| core_xfer_busy | input | 1 | High while the core runs an external memory access |
| addr_oe | output | 1 | Address bus driver enable, 1 = core drives |
| data_oe | output | 1 | Data bus driver enable, 1 = core drives |
| strobe_oe | output | N_STROBES | Per-strobe driver enables, order as in R3 |
| ext_grant_n | output | 1 | Active-low bus grant to the outside master |
| core_halt | output | 1 | Stops core execution while high |

## Verification
A request change reaches the grant state on the (SYNC_STAGES+1)-th rising edge, because it passes the synchronizer stages and the state register. A release reaches the grant pin after the same count, and it reaches the enables and the halt one edge later. A drop of `core_xfer_busy` during a deferred request shows up on the very next edge. Inputs change just after a falling edge, and all outputs are sampled on falling edges. A behavioural model clocked on the same rising edges predicts each output. Directed checks then count these exact edge distances for the basic, deferred, withdrawn and one-cycle-pulse cases.

// File: rtl/bha_pkg.sv
package bha_pkg;

  // Hand-off state encoding
  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_WAIT    = 2'd1,
    ST_GRANT   = 2'd2,
    ST_RELEASE = 2'd3
  } arb_state_t;

  // Strobe positions in strobe_oe (R3)
  localparam int STB_PROG  = 0;
  localparam int STB_DATA  = 1;
  localparam int STB_BYTE  = 2;
  localparam int STB_COMP  = 3;
  localparam int STB_IO    = 4;
  localparam int STB_RD    = 5;
  localparam int STB_WR    = 6;
  localparam int STB_COUNT = 7;

endpackage

// File: rtl/bha_req_sync.sv
module bha_req_sync #(
  parameter int   STAGES    = 2,
  parameter logic RESET_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic sync_out
);

  logic [STAGES-1:0] chain;

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[g] <= RESET_VAL;
          else        chain[g] <= async_in;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[g] <= RESET_VAL;
          else        chain[g] <= chain[g-1];
        end
      end
    end
  endgenerate

  assign sync_out = chain[STAGES-1];

endmodule

// File: rtl/bha_grant_fsm.sv
module bha_grant_fsm
  import bha_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       req_active,
  input  logic       xfer_busy,
  output arb_state_t state
);

  arb_state_t state_nxt;

  always_comb begin
    state_nxt = state;
    unique case (state)
      ST_IDLE: begin
        if (req_active) state_nxt = xfer_busy ? ST_WAIT : ST_GRANT;
      end
      ST_WAIT: begin
        // withdrawn request wins over a finishing access (R8)
        if (!req_active)     state_nxt = ST_IDLE;
        else if (!xfer_busy) state_nxt = ST_GRANT;
      end
      ST_GRANT: begin
        if (!req_active) state_nxt = ST_RELEASE;
      end
      ST_RELEASE: begin
        state_nxt = ST_IDLE;
      end
      default: state_nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_IDLE;
    else        state <= state_nxt;
  end

endmodule

// File: rtl/bha_drive_ctrl.sv
module bha_drive_ctrl
  import bha_pkg::*;
#(
  parameter int N_STROBES = STB_COUNT
) (
  input  arb_state_t           state,
  output logic                 addr_oe,
  output logic                 data_oe,
  output logic [N_STROBES-1:0] strobe_oe,
  output logic                 grant_n,
  output logic                 halt
);

  logic core_owns_bus;

  // Core keeps the drivers only while it has not given the bus away
  assign core_owns_bus = (state == ST_IDLE) || (state == ST_WAIT);

  assign addr_oe = core_owns_bus;
  assign data_oe = core_owns_bus;
  assign grant_n = (state != ST_GRANT);
  assign halt    = (state == ST_GRANT) || (state == ST_RELEASE);

  genvar s;
  generate
    for (s = 0; s < N_STROBES; s++) begin : g_strobe
      assign strobe_oe[s] = core_owns_bus;
    end
  endgenerate

endmodule

// File: rtl/bus_handoff_arbiter.sv
module bus_handoff_arbiter
  import bha_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int N_STROBES   = STB_COUNT
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 ext_req_n,
  input  logic                 core_xfer_busy,
  output logic                 addr_oe,
  output logic                 data_oe,
  output logic [N_STROBES-1:0] strobe_oe,
  output logic                 ext_grant_n,
  output logic                 core_halt
);

  logic       req_n_sync;
  logic       req_active;
  arb_state_t arb_state;

  bha_req_sync #(
    .STAGES   (SYNC_STAGES),
    .RESET_VAL(1'b1)
  ) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .async_in(ext_req_n),
    .sync_out(req_n_sync)
  );

  assign req_active = !req_n_sync;

  bha_grant_fsm u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_active(req_active),
    .xfer_busy (core_xfer_busy),
    .state     (arb_state)
  );

  bha_drive_ctrl #(
    .N_STROBES(N_STROBES)
  ) u_drive (
    .state    (arb_state),
    .addr_oe  (addr_oe),
    .data_oe  (data_oe),
    .strobe_oe(strobe_oe),
    .grant_n  (ext_grant_n),
    .halt     (core_halt)
  );

endmodule

// File: rtl/bha_checker.sv
module bha_checker #(
  parameter int N_STROBES = 7
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 core_xfer_busy,
  input logic                 addr_oe,
  input logic                 data_oe,
  input logic [N_STROBES-1:0] strobe_oe,
  input logic                 ext_grant_n,
  input logic                 core_halt
);

  assert_grant_floats_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !ext_grant_n |-> (!addr_oe && !data_oe && strobe_oe == '0));

  assert_no_grant_while_driving_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_oe || data_oe || strobe_oe != '0) |-> ext_grant_n);

  assert_halt_with_grant_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !ext_grant_n |-> core_halt);

  assert_grant_after_idle_core_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ext_grant_n) |-> !$past(core_xfer_busy));

  assert_release_cycle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ext_grant_n) |-> (!addr_oe && core_halt));

  assert_reenable_next_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ext_grant_n) |=> (addr_oe && data_oe && !core_halt));

  assert_drop_only_with_grant_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(addr_oe) |-> !ext_grant_n);

endmodule

bind bus_handoff_arbiter bha_checker #(.N_STROBES(N_STROBES)) u_bha_checker (
  .clk           (clk),
  .rst_n         (rst_n),
  .core_xfer_busy(core_xfer_busy),
  .addr_oe       (addr_oe),
  .data_oe       (data_oe),
  .strobe_oe     (strobe_oe),
  .ext_grant_n   (ext_grant_n),
  .core_halt     (core_halt)
);

// File: tb/test_bus_handoff_arbiter.sv
`timescale 1ns/1ps
module test_bus_handoff_arbiter;

  localparam int NS = 7;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          ext_req_n = 1'b1;
  logic          core_xfer_busy = 1'b0;
  logic          addr_oe, data_oe, ext_grant_n, core_halt;
  logic [NS-1:0] strobe_oe;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  bus_handoff_arbiter #(.SYNC_STAGES(2), .N_STROBES(NS)) i_bus_handoff_arbiter (
    .clk(clk), .rst_n(rst_n), .ext_req_n(ext_req_n), .core_xfer_busy(core_xfer_busy),
    .addr_oe(addr_oe), .data_oe(data_oe), .strobe_oe(strobe_oe),
    .ext_grant_n(ext_grant_n), .core_halt(core_halt)
  );

  // Behavioural reference: request pipeline as a queue, phase as an integer
  // phase 0 free, 1 deferred, 2 granted, 3 giving back
  bit q_req[$];
  int phase;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_req = {};
      q_req.push_back(1'b0);
      q_req.push_back(1'b0);
      phase = 0;
    end else begin
      bit wants;
      wants = q_req.pop_front();
      q_req.push_back(!ext_req_n);
      case (phase)
        0: if (wants) phase = core_xfer_busy ? 1 : 2;
        1: if (!wants) phase = 0; else if (!core_xfer_busy) phase = 2;
        2: if (!wants) phase = 3;
        default: phase = 0;
      endcase
    end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  // Compare against the model on every falling edge
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      bit free;
      free = (phase < 2);
      check("R4 grant vs model", ext_grant_n, (phase == 2) ? 0 : 1);
      check("R3 addr_oe vs model", addr_oe, free);
      check("R3 data_oe vs model", data_oe, free);
      check("R3 strobe_oe vs model", strobe_oe, free ? {NS{1'b1}} : '0);
      check("R5 halt vs model", core_halt, free ? 0 : 1);
    end
  end

  task automatic edges(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic drive_req(input logic v);
    #1 ext_req_n = v;
  endtask

  task automatic drive_busy(input logic v);
    #1 core_xfer_busy = v;
  endtask

  task automatic finish_run();
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #40000;
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    edges(1);
    // R1 during reset
    check("R1 grant in reset", ext_grant_n, 1);
    check("R1 halt in reset", core_halt, 0);
    check("R1 strobes in reset", {addr_oe, data_oe, strobe_oe}, {(NS+2){1'b1}});
    edges(2);
    #1 rst_n = 1'b1;
    edges(2);
    check("R1 after reset", {ext_grant_n, addr_oe, core_halt}, 3'b110);

    // R2 basic grant latency: third edge
    drive_req(1'b0);
    edges(2);
    check("R2 no grant at edge 2", ext_grant_n, 1);
    edges(1);
    check("R2 grant at edge 3", ext_grant_n, 0);
    check("R3 strobes floated", strobe_oe, 0);
    check("R5 halted", core_halt, 1);
    // busy toggling while granted changes nothing (R4)
    drive_busy(1'b1);
    edges(3);
    check("R4 grant held with busy", ext_grant_n, 0);
    drive_busy(1'b0);
    edges(2);

    // R7 release order
    drive_req(1'b1);
    edges(3);
    check("R7 grant dropped", ext_grant_n, 1);
    check("R7 drivers still off", addr_oe, 0);
    check("R7 still halted", core_halt, 1);
    edges(1);
    check("R7 drivers back", {addr_oe, data_oe}, 2'b11);
    check("R7 halt cleared", core_halt, 0);
    edges(3);

    // R6 deferral behind a core access
    drive_busy(1'b1);
    edges(1);
    drive_req(1'b0);
    edges(6);
    check("R6 grant deferred", ext_grant_n, 1);
    check("R6 drivers kept", addr_oe, 1);
    drive_busy(1'b0);
    edges(1);
    check("R6 grant after busy end", ext_grant_n, 0);
    edges(2);
    drive_req(1'b1);
    edges(6);

    // R8 withdrawal while deferred
    drive_busy(1'b1);
    edges(1);
    drive_req(1'b0);
    edges(4);
    drive_req(1'b1);
    edges(4);
    drive_busy(1'b0);
    edges(4);
    check("R8 no grant after withdraw", ext_grant_n, 1);
    check("R8 drivers kept", {addr_oe, core_halt}, 2'b10);

    // one-cycle request pulse: brief grant then release (R2, R7)
    drive_req(1'b0);
    edges(1);
    drive_req(1'b1);
    edges(2);
    check("R2 pulse granted", ext_grant_n, 0);
    edges(1);
    check("R7 pulse released", {ext_grant_n, addr_oe}, 2'b10);
    edges(1);
    check("R7 pulse drivers back", addr_oe, 1);

    // random traffic against the model
    for (int k = 0; k < 400; k++) begin
      if (($urandom % 7) == 0) drive_req(~ext_req_n);
      else if (($urandom % 5) == 0) drive_busy(~core_xfer_busy);
      edges(1);
    end
    drive_req(1'b1);
    drive_busy(1'b0);
    edges(6);
    finish_run();
  end

endmodule